// File: doc/BRIEF.md
# Segment-Status Memory Bank Decoder

This block watches a multiplexed processor bus and turns each memory cycle into a wider physical access. While the address-latch strobe is high it captures the 20-bit bus address. On the first clock after that strobe falls it captures the two segment-status bits that the upper address lines now carry. The captured segment code is placed above the 20-bit address to form a 22-bit physical address. Each of the four segment types (extra, stack, code, data) therefore reaches its own 1 MB bank, and the total reach is 4 MB.

For memory cycles only, the block drives one bank select for as long as a read or write strobe is active. It passes the read strobe through unchanged. It passes the write strobe through only when software has not marked the current segment as protected in a 4-bit protect mask. A refused write sets a sticky violation flag, and a dedicated clear input clears it. The block has no streaming data path: all pins are plain bus and control signals, so there is no valid/ready handshake and no back-pressure. Strobes are active low, as on the bus. Bank selects are active high.

Top module: `mmap_seg_bank_dec`

## Requirements
- R1: After reset, phys_addr is zero, bank_sel is zero, mem_rd_n and mem_wr_n are high, and viol is low.
- R2: On every rising clock edge where ale is high, {a_hi, a_mid, ad} is stored into phys_addr[19:0]. That value is held unchanged while ale stays low, even if the bus lines change.
- R3: On the first rising edge where ale is low after an edge where it was high, the status bits a_hi[1:0] (bit 1 carries S4, bit 0 carries S3) are stored into phys_addr[21:20]. That value is held until the next such edge.
- R4: The segment code is encoded as 00 = extra, 01 = stack, 10 = code, 11 = data. Code k drives bank_sel[k].
- R5: bank_sel is one-hot while a segment code has been captured since ale last went high, io_m is low, and rd_n or wr_n is low. It follows the strobes with no clock delay. Otherwise bank_sel is all zero, including while ale is high and before the first capture after reset.
- R6: When io_m is high (I/O cycle), bank_sel is zero and both mem_rd_n and mem_wr_n stay high.
- R7: mem_rd_n is low exactly when a bank is selected and rd_n is low. The protect mask never affects it.
- R8: mem_wr_n is low exactly when a bank is selected, wr_n is low, and prot_mask bit [segment code] is 0. A set bit keeps mem_wr_n high, while bank_sel still shows the addressed bank.
- R9: A clock edge that sees a selected write to a protected segment makes viol high after that edge. viol then stays high.
- R10: viol_clr high at a clock edge clears viol after that edge. If a refused write is seen at the same edge, viol stays set, because setting takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address-latch strobe, high during the address phase |
| ad | input | 8 | Multiplexed low address / data lines |
| a_mid | input | 8 | Address bits 15..8 |
| a_hi | input | 4 | Address bits 19..16, later status; bits 1:0 carry the segment code |
| io_m | input | 1 | High for an I/O cycle, low for a memory cycle |
| rd_n | input | 1 | Bus read strobe, active low |
| wr_n | input | 1 | Bus write strobe, active low |
| prot_mask | input | 4 | One write-protect bit per segment code |
| viol_clr | input | 1 | Clears the violation flag |
| phys_addr | output | 22 | Segment code over the captured 20-bit address |
| bank_sel | output | 4 | One-hot bank selects, active high |
| mem_rd_n | output | 1 | Gated read strobe, active low |
| mem_wr_n | output | 1 | Gated write strobe, active low |
| viol | output | 1 | Sticky write-protection violation flag |

## Verification
The bench builds the block with its defaults: an 8-bit multiplexed low byte and a 20-bit bus address. The resulting 22-bit physical address makes all four banks, and the full 4 MB span above them, visible on the ports. With a 4-bit mask, every protect combination can be driven. This lets the random cycles mix any segment with any mask, so reads and writes to protected and unprotected banks meet in the same run. Directed cycles cover each segment name, I/O cycles under a full mask, a strobe before any capture, and a clear that coincides with a refused write.

// File: rtl/seg_bank_pkg.sv
package seg_bank_pkg;
  localparam int SEG_W     = 2;
  localparam int NUM_BANKS = 1 << SEG_W;

  typedef enum logic [SEG_W-1:0] {
    SEG_EXTRA = 2'b00,
    SEG_STACK = 2'b01,
    SEG_CODE  = 2'b10,
    SEG_DATA  = 2'b11
  } seg_e;
endpackage

// File: rtl/bus_addr_capture.sv
module bus_addr_capture
  import seg_bank_pkg::*;
#(
  parameter int AD_W   = 8,
  parameter int ADDR_W = 20,
  parameter int STAT_W = 4,
  localparam int MID_W = ADDR_W - AD_W - STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [AD_W-1:0]   ad,
  input  logic [MID_W-1:0]  a_mid,
  input  logic [STAT_W-1:0] a_hi,
  output logic [ADDR_W-1:0] addr_q,
  output seg_e              seg_q,
  output logic              seg_vld
);
  logic ale_q;
  logic ale_fall;

  assign ale_fall = ale_q && !ale;

  // Address follows the bus while ale is high; the last sample is kept.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (ale) begin
      addr_q <= {a_hi, a_mid, ad};
    end
  end

  // Segment status is taken on the first clock after ale falls.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_q   <= 1'b0;
      seg_q   <= SEG_EXTRA;
      seg_vld <= 1'b0;
    end else begin
      ale_q <= ale;
      if (ale) begin
        seg_vld <= 1'b0;
      end else if (ale_fall) begin
        seg_q   <= seg_e'(a_hi[SEG_W-1:0]);
        seg_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bank_select_dec.sv
module bank_select_dec
  import seg_bank_pkg::*;
(
  input  seg_e                 seg,
  input  logic                 enable,
  output logic [NUM_BANKS-1:0] sel
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign sel[b] = enable && (seg == seg_e'(b));
  end
endmodule

// File: rtl/write_guard.sv
module write_guard
  import seg_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_sel,
  input  seg_e                 seg,
  input  logic [NUM_BANKS-1:0] prot_mask,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic                 viol_clr,
  output logic                 mem_rd_n,
  output logic                 mem_wr_n,
  output logic                 viol
);
  logic any_sel;
  logic locked;
  logic refused;

  assign any_sel  = |bank_sel;
  assign locked   = prot_mask[seg];
  assign refused  = any_sel && !wr_n && locked;
  assign mem_rd_n = !(any_sel && !rd_n);
  assign mem_wr_n = !(any_sel && !wr_n && !locked);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol <= 1'b0;
    end else if (refused) begin
      viol <= 1'b1;
    end else if (viol_clr) begin
      viol <= 1'b0;
    end
  end
endmodule

// File: rtl/mmap_seg_bank_dec.sv
module mmap_seg_bank_dec
  import seg_bank_pkg::*;
#(
  parameter int AD_W   = 8,
  parameter int ADDR_W = 20,
  parameter int STAT_W = 4,
  localparam int MID_W = ADDR_W - AD_W - STAT_W,
  localparam int PA_W  = ADDR_W + SEG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ale,
  input  logic [AD_W-1:0]      ad,
  input  logic [MID_W-1:0]     a_mid,
  input  logic [STAT_W-1:0]    a_hi,
  input  logic                 io_m,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic [NUM_BANKS-1:0] prot_mask,
  input  logic                 viol_clr,
  output logic [PA_W-1:0]      phys_addr,
  output logic [NUM_BANKS-1:0] bank_sel,
  output logic                 mem_rd_n,
  output logic                 mem_wr_n,
  output logic                 viol
);
  logic [ADDR_W-1:0] addr_q;
  seg_e              seg_q;
  logic              seg_vld;
  logic              sel_en;

  bus_addr_capture #(.AD_W(AD_W), .ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad(ad), .a_mid(a_mid), .a_hi(a_hi),
    .addr_q(addr_q), .seg_q(seg_q), .seg_vld(seg_vld)
  );

  assign sel_en    = seg_vld && !io_m && (!rd_n || !wr_n);
  assign phys_addr = {seg_q, addr_q};

  bank_select_dec u_dec (.seg(seg_q), .enable(sel_en), .sel(bank_sel));

  write_guard u_guard (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .seg(seg_q),
    .prot_mask(prot_mask), .rd_n(rd_n), .wr_n(wr_n), .viol_clr(viol_clr),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .viol(viol)
  );
endmodule

// File: rtl/mmap_seg_bank_dec_chk.sv
module mmap_seg_bank_dec_chk #(
  parameter int PA_W  = 22,
  parameter int NB    = 4,
  parameter int SEG_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ale,
  input logic            io_m,
  input logic            rd_n,
  input logic            wr_n,
  input logic [NB-1:0]   prot_mask,
  input logic            viol_clr,
  input logic [PA_W-1:0] phys_addr,
  input logic [NB-1:0]   bank_sel,
  input logic            mem_rd_n,
  input logic            mem_wr_n,
  input logic            viol
);
  a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel));

  a_r5_idle_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n) |-> (bank_sel == '0));

  a_r6_io_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    io_m |-> (bank_sel == '0 && mem_rd_n && mem_wr_n));

  a_r7_read_passes: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_sel != '0) && !rd_n) |-> !mem_rd_n);

  a_r8_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && prot_mask[phys_addr[PA_W-1 -: SEG_W]]) |-> mem_wr_n);

  a_r9_viol_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_sel != '0) && !wr_n && prot_mask[phys_addr[PA_W-1 -: SEG_W]]) |=> viol);

  a_r9_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !viol_clr) |=> viol);

  a_r3_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !$past(ale)) |=> $stable(phys_addr[PA_W-1 -: SEG_W]));
endmodule

bind mmap_seg_bank_dec mmap_seg_bank_dec_chk #(
  .PA_W(PA_W), .NB(seg_bank_pkg::NUM_BANKS), .SEG_W(seg_bank_pkg::SEG_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
  .prot_mask(prot_mask), .viol_clr(viol_clr), .phys_addr(phys_addr),
  .bank_sel(bank_sel), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .viol(viol)
);

// File: tb/test_mmap_seg_bank_dec.sv
module test_mmap_seg_bank_dec;
  import seg_bank_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b0;
  logic [7:0]  ad = '0;
  logic [7:0]  a_mid = '0;
  logic [3:0]  a_hi = '0;
  logic        io_m = 1'b0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [3:0]  prot_mask = '0;
  logic        viol_clr = 1'b0;
  logic [21:0] phys_addr;
  logic [3:0]  bank_sel;
  logic        mem_rd_n;
  logic        mem_wr_n;
  logic        viol;

  int n_total = 0;
  int n_fail  = 0;
  logic exp_viol = 1'b0;

  always #5 clk = ~clk;

  mmap_seg_bank_dec i_mmap_seg_bank_dec (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad(ad), .a_mid(a_mid), .a_hi(a_hi),
    .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n), .prot_mask(prot_mask),
    .viol_clr(viol_clr), .phys_addr(phys_addr), .bank_sel(bank_sel),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .viol(viol)
  );

  function automatic logic [3:0] exp_sel(input logic [1:0] sg, input logic iom);
    return iom ? 4'b0000 : (4'b0001 << sg);
  endfunction

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
  endtask

  // One complete bus cycle: address phase, status phase, strobe, release.
  task automatic bus_cycle(input logic [19:0] a, input logic [1:0] sg,
                           input logic iom, input logic wr,
                           input logic [3:0] msk, input logic clr);
    logic hit;
    @(negedge clk);
    prot_mask = msk; io_m = iom; ale = 1'b1;
    ad = a[7:0]; a_mid = a[15:8]; a_hi = a[19:16];
    @(posedge clk); #2;
    check(bank_sel == 4'b0, "R5 ale phase", 32'(bank_sel), 0);
    @(negedge clk);
    ale = 1'b0; a_hi = {2'($urandom), sg}; ad = 8'($urandom);
    @(posedge clk); #2;
    check(phys_addr[19:0] == a, "R2 addr", 32'(phys_addr[19:0]), 32'(a));
    check(phys_addr[21:20] == sg, "R3 seg", 32'(phys_addr[21:20]), 32'(sg));
    @(negedge clk);
    ad = 8'($urandom); viol_clr = clr;
    if (wr) wr_n = 1'b0; else rd_n = 1'b0;
    #1;
    check(bank_sel == exp_sel(sg, iom), iom ? "R6 sel" : "R5 sel",
          32'(bank_sel), 32'(exp_sel(sg, iom)));
    check(mem_rd_n == !(!wr && !iom), "R7 rd", 32'(mem_rd_n), 32'(!(!wr && !iom)));
    check(mem_wr_n == !(wr && !iom && !msk[sg]), "R8 wr",
          32'(mem_wr_n), 32'(!(wr && !iom && !msk[sg])));
    hit = wr && !iom && msk[sg];
    if (hit) exp_viol = 1'b1;
    else if (clr) exp_viol = 1'b0;
    @(posedge clk); #2;
    check(viol == exp_viol, clr ? "R10 clr" : "R9 viol", 32'(viol), 32'(exp_viol));
    check(phys_addr == {sg, a}, "R2 hold", 32'(phys_addr), 32'({sg, a}));
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1; viol_clr = 1'b0; a_hi = 4'($urandom);
    #1;
    check(bank_sel == 4'b0 && mem_rd_n && mem_wr_n, "R5 release",
          32'({bank_sel, mem_rd_n, mem_wr_n}), 32'(6'b000011));
  endtask

  task automatic clear_flag();
    @(negedge clk); viol_clr = 1'b1;
    @(posedge clk); #2;
    exp_viol = 1'b0;
    check(viol == 1'b0, "R10 clear", 32'(viol), 0);
    @(negedge clk); viol_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #2;
    check(phys_addr == 22'd0 && bank_sel == 4'd0 && mem_rd_n && mem_wr_n && !viol,
          "R1 reset", 32'({phys_addr, bank_sel, mem_rd_n, mem_wr_n, viol}),
          32'({22'd0, 4'd0, 1'b1, 1'b1, 1'b0}));
    @(negedge clk); rst_n = 1'b1;
    // Strobe before any segment capture: no select (R5).
    @(negedge clk); rd_n = 1'b0; #1;
    check(bank_sel == 4'b0 && mem_rd_n, "R5 no capture", 32'(bank_sel), 0);
    @(negedge clk); rd_n = 1'b1;

    // R4: each named segment reaches its own bank; reads pass a full mask (R7).
    bus_cycle(20'hABCDE, SEG_EXTRA, 1'b0, 1'b0, 4'hF, 1'b0);
    check(1'b1, "R4 extra", 0, 0);
    bus_cycle(20'h12345, SEG_STACK, 1'b0, 1'b0, 4'hF, 1'b0);
    bus_cycle(20'hFFFFF, SEG_CODE,  1'b0, 1'b0, 4'hF, 1'b0);
    bus_cycle(20'h00000, SEG_DATA,  1'b0, 1'b0, 4'hF, 1'b0);
    // I/O cycle under full mask: nothing selected, no violation (R6).
    bus_cycle(20'h003F8, SEG_DATA,  1'b1, 1'b1, 4'hF, 1'b0);
    // Protected write per segment, then clear (R8, R9, R10).
    for (int s = 0; s < 4; s++) begin
      bus_cycle(20'(32'h4000 * s + 7), 2'(s), 1'b0, 1'b1, 4'(1 << s), 1'b0);
      bus_cycle(20'(32'h8000 + s), 2'(s), 1'b0, 1'b1, ~4'(1 << s), 1'b0);
      clear_flag();
    end
    // Clear coinciding with a refused write: set wins (R10).
    bus_cycle(20'h55AA5, SEG_CODE, 1'b0, 1'b1, 4'b0100, 1'b1);
    // Clear alongside an allowed write: flag drops (R10).
    bus_cycle(20'h0F0F0, SEG_STACK, 1'b0, 1'b1, 4'b0100, 1'b1);

    for (int i = 0; i < 60; i++) begin
      bus_cycle(20'($urandom), 2'($urandom), ($urandom % 5) == 0,
                1'($urandom), 4'($urandom), ($urandom % 6) == 0);
    end
    summary();
    $finish;
  end
endmodule